// File: doc/BRIEF.md
# Triggered Switch-Timing Sequencer

This block generates three active-low control lines for the analog switches of a switched-integrator front end: one for the integrator discharge (reset) switch, one for the output select switch and one for the input hold switch. Logic 0 on a line closes its switch and logic 1 opens it. The same three lines serve both channels of a dual integrator. A rising edge on the trigger input starts one measurement cycle. An internal row sequencer first waits one step interval, then walks through rows 1 to 10. It spends a programmable number of clock cycles, the step interval, on each row.

Six routing masks map rows onto six control columns. Each column is the OR of the rows enabled in its mask. Each control line has one column that closes its switch and one that opens it. Each column acts on the line when it turns on. A terminal-row setting shortens the sequence. A combinational flag reports any routing in which the reset switch opens on the same row as the hold switch closes, because that placement can lose the integrated sample. The block has no streaming data path, so every pin is a plain level signal.

Top module: `swtime_seq`

## Requirements
- R1: While rst_n is low, and after it is released, reset_sw_o, select_sw_o and hold_sw_o are 1 (all switches open) and row_o equals 1 (bit 0 only, the idle row).
- R2: row_o is one-hot. A trigger rising edge is sampled on clock edge E0 while the sequencer is idle. Row r (bit r of row_o, r = 1..10) is then active after edges E0+r*P through E0+r*P+P-1, where P is pulse_cycles_i. After the last row the bus returns to bit 0.
- R3: term_row_i = N with 1 <= N <= 10 keeps row N and every higher row at zero, and the sequence ends after row N-1. N = 0 or N = 11..15 produces all ten rows.
- R4: A trigger rising edge that arrives while a sequence is running is ignored. The running sequence keeps its timing, and no new sequence follows it.
- R5: Bit i of each routing mask enables row i+1 on that column. A column edge changes its control output on the clock edge after the edge that changed row_o.
- R6: reset_sw_o goes to 0 when its close column (rst_close_rows_i) turns on, and to 1 when its open column (rst_open_rows_i) turns on.
- R7: select_sw_o goes to 0 when sel_close_rows_i's column turns on, and to 1 when sel_open_rows_i's column turns on.
- R8: hold_sw_o goes to 1 when hold_open_rows_i's column turns on, and to 0 when hold_close_rows_i's column turns on.
- R9: When the close and open columns of one output turn on together, the output goes to 0. It returns to 1 one clock after the open column turns off, which gives a low pulse exactly P cycles long for a single-row column.
- R10: hazard_o is 1 exactly when some enabled row turns on both the reset open column and the hold close column, where a column turns on at a row that is in its mask while the previous row is not. Rows cut off by the terminal setting do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| trig_i | input | 1 | Cycle trigger; a rising edge starts a sequence |
| pulse_cycles_i | input | 16 | Step interval P in clock cycles |
| term_row_i | input | 4 | Terminal row; 0 selects all ten rows |
| rst_close_rows_i | input | 10 | Rows that close the reset switch |
| rst_open_rows_i | input | 10 | Rows that open the reset switch |
| sel_close_rows_i | input | 10 | Rows that close the select switch |
| sel_open_rows_i | input | 10 | Rows that open the select switch |
| hold_close_rows_i | input | 10 | Rows that close the hold switch |
| hold_open_rows_i | input | 10 | Rows that open the hold switch |
| reset_sw_o | output | 1 | Reset switch control, 0 = closed |
| select_sw_o | output | 1 | Select switch control, 0 = closed |
| hold_sw_o | output | 1 | Hold switch control, 0 = closed |
| row_o | output | 11 | One-hot current row, bit 0 = idle |
| hazard_o | output | 1 | Reset-open and hold-close edges coincide |

## Verification
The properties assume that the routing masks, the terminal setting and the step interval change only while the row bus shows the idle row. A mask edit in the middle of a sequence could make a column turn on with no row change. It could also leave rows above the terminal that were already active. The stimulus therefore writes every configuration before it raises the trigger and waits for the bus to return to bit 0 before it writes the next one. The step interval is always at least one cycle.

// File: rtl/swtime_pkg.sv
package swtime_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
  localparam int NUM_CTL    = 3;
  localparam int CTL_RESET  = 0;
  localparam int CTL_SELECT = 1;
  localparam int CTL_HOLD   = 2;
endpackage

// File: rtl/swtime_rowgen.sv
module swtime_rowgen
  import swtime_pkg::*;
#(
  parameter int NROWS  = 10,
  parameter int PW_W   = 16,
  parameter int TERM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [PW_W-1:0]   pulse_cycles_i,
  input  logic [TERM_W-1:0] term_row_i,
  output logic [NROWS:0]    row_o
);
  seq_state_e        state_q;
  logic              trig_q;
  logic [PW_W-1:0]   cnt_q;
  logic [TERM_W-1:0] cur_q;
  logic [TERM_W-1:0] last_row;
  logic [PW_W:0]     cnt_nx;
  logic              step;

  // last row actually produced in this cycle
  always_comb begin
    if (term_row_i == '0 || term_row_i > TERM_W'(NROWS))
      last_row = TERM_W'(NROWS);
    else
      last_row = term_row_i - 1'b1;
  end

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign step   = cnt_nx >= {1'b0, pulse_cycles_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      trig_q  <= 1'b0;
      cnt_q   <= '0;
      cur_q   <= '0;
    end else begin
      trig_q <= trig_i;
      case (state_q)
        SEQ_IDLE: begin
          if (trig_i && !trig_q) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
            cur_q   <= '0;
          end
        end
        default: begin
          if (step) begin
            cnt_q <= '0;
            if (cur_q == last_row) begin
              state_q <= SEQ_IDLE;
              cur_q   <= '0;
            end else begin
              cur_q <= cur_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_nx[PW_W-1:0];
          end
        end
      endcase
    end
  end

  always_comb begin
    row_o        = '0;
    row_o[cur_q] = 1'b1;
  end
endmodule

// File: rtl/swtime_ctl.sv
module swtime_ctl #(
  parameter int NROWS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NROWS-1:0] rows_i,
  input  logic [NROWS-1:0] close_mask_i,
  input  logic [NROWS-1:0] open_mask_i,
  output logic             sw_o
);
  logic close_col, open_col;
  logic close_q, open_q, pend_q, sw_q;
  logic close_rise, open_rise, open_fall;

  assign close_col  = |(rows_i & close_mask_i);
  assign open_col   = |(rows_i & open_mask_i);
  assign close_rise = close_col & ~close_q;
  assign open_rise  = open_col & ~open_q;
  assign open_fall  = open_q & ~open_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      close_q <= 1'b0;
      open_q  <= 1'b0;
      pend_q  <= 1'b0;
      sw_q    <= 1'b1;
    end else begin
      close_q <= close_col;
      open_q  <= open_col;
      if (close_rise) begin
        sw_q   <= 1'b0;
        pend_q <= open_rise;   // opening deferred to the end of the row
      end else if (open_rise) begin
        sw_q   <= 1'b1;
        pend_q <= 1'b0;
      end else if (pend_q && open_fall) begin
        sw_q   <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/swtime_hazard.sv
module swtime_hazard #(
  parameter int NROWS  = 10,
  parameter int TERM_W = 4
) (
  input  logic [TERM_W-1:0] term_row_i,
  input  logic [NROWS-1:0]  rst_open_mask_i,
  input  logic [NROWS-1:0]  hold_close_mask_i,
  output logic              hazard_o
);
  logic [NROWS-1:0] en, b_m, f_m, b_r, f_r;

  for (genvar i = 0; i < NROWS; i++) begin : g_en
    assign en[i] = (term_row_i == '0) || (term_row_i > TERM_W'(NROWS)) ||
                   (TERM_W'(i + 1) < term_row_i);
  end

  assign b_m      = rst_open_mask_i & en;
  assign f_m      = hold_close_mask_i & en;
  assign b_r      = b_m & ~{b_m[NROWS-2:0], 1'b0};
  assign f_r      = f_m & ~{f_m[NROWS-2:0], 1'b0};
  assign hazard_o = |(b_r & f_r);
endmodule

// File: rtl/swtime_seq.sv
module swtime_seq
  import swtime_pkg::*;
#(
  parameter int NROWS = 10,
  parameter int PW_W  = 16,
  localparam int TERM_W = $clog2(NROWS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [PW_W-1:0]   pulse_cycles_i,
  input  logic [TERM_W-1:0] term_row_i,
  input  logic [NROWS-1:0]  rst_close_rows_i,
  input  logic [NROWS-1:0]  rst_open_rows_i,
  input  logic [NROWS-1:0]  sel_close_rows_i,
  input  logic [NROWS-1:0]  sel_open_rows_i,
  input  logic [NROWS-1:0]  hold_close_rows_i,
  input  logic [NROWS-1:0]  hold_open_rows_i,
  output logic              reset_sw_o,
  output logic              select_sw_o,
  output logic              hold_sw_o,
  output logic [NROWS:0]    row_o,
  output logic              hazard_o
);
  logic [NUM_CTL-1:0][NROWS-1:0] close_m, open_m;
  logic [NUM_CTL-1:0]            sw;

  assign close_m[CTL_RESET]  = rst_close_rows_i;
  assign open_m[CTL_RESET]   = rst_open_rows_i;
  assign close_m[CTL_SELECT] = sel_close_rows_i;
  assign open_m[CTL_SELECT]  = sel_open_rows_i;
  assign close_m[CTL_HOLD]   = hold_close_rows_i;
  assign open_m[CTL_HOLD]    = hold_open_rows_i;

  swtime_rowgen #(.NROWS(NROWS), .PW_W(PW_W), .TERM_W(TERM_W)) u_rowgen (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
    .pulse_cycles_i(pulse_cycles_i), .term_row_i(term_row_i), .row_o(row_o)
  );

  for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
    swtime_ctl #(.NROWS(NROWS)) u_ctl (
      .clk(clk), .rst_n(rst_n), .rows_i(row_o[NROWS:1]),
      .close_mask_i(close_m[c]), .open_mask_i(open_m[c]), .sw_o(sw[c])
    );
  end

  swtime_hazard #(.NROWS(NROWS), .TERM_W(TERM_W)) u_hazard (
    .term_row_i(term_row_i), .rst_open_mask_i(rst_open_rows_i),
    .hold_close_mask_i(hold_close_rows_i), .hazard_o(hazard_o)
  );

  assign reset_sw_o  = sw[CTL_RESET];
  assign select_sw_o = sw[CTL_SELECT];
  assign hold_sw_o   = sw[CTL_HOLD];
endmodule

// File: rtl/swtime_seq_chk.sv
module swtime_seq_chk #(
  parameter int NROWS  = 10,
  parameter int TERM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TERM_W-1:0] term_row_i,
  input logic [NROWS-1:0]  rst_close_rows_i,
  input logic [NROWS-1:0]  sel_close_rows_i,
  input logic [NROWS-1:0]  hold_close_rows_i,
  input logic [NROWS-1:0]  hold_open_rows_i,
  input logic              reset_sw_o,
  input logic              select_sw_o,
  input logic              hold_sw_o,
  input logic [NROWS:0]    row_o
);
  logic rc_col, sc_col, hc_col, ho_col;
  assign rc_col = |(rst_close_rows_i & row_o[NROWS:1]);
  assign sc_col = |(sel_close_rows_i & row_o[NROWS:1]);
  assign hc_col = |(hold_close_rows_i & row_o[NROWS:1]);
  assign ho_col = |(hold_open_rows_i & row_o[NROWS:1]);

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(row_o) == 1); // R2
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(row_o) |-> ((row_o == ($past(row_o) << 1)) || (row_o == (NROWS+1)'(1)))); // R2
  AST_TERM_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n) (term_row_i != '0 && term_row_i <= TERM_W'(NROWS)) |-> ((row_o >> term_row_i) == '0)); // R3
  AST_RESET_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rc_col) |=> !reset_sw_o); // R6
  AST_SELECT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sc_col) |=> !select_sw_o); // R7
  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rst_n) ($rose(ho_col) && !$rose(hc_col)) |=> hold_sw_o); // R8
endmodule

bind swtime_seq swtime_seq_chk #(.NROWS(NROWS), .TERM_W(TERM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .term_row_i(term_row_i),
  .rst_close_rows_i(rst_close_rows_i), .sel_close_rows_i(sel_close_rows_i),
  .hold_close_rows_i(hold_close_rows_i), .hold_open_rows_i(hold_open_rows_i),
  .reset_sw_o(reset_sw_o), .select_sw_o(select_sw_o), .hold_sw_o(hold_sw_o),
  .row_o(row_o)
);

// File: tb/swtime_seq_test.sv
module swtime_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] pw = 16'd4;
  logic [3:0]  term = 4'd0;
  logic [9:0]  rc, ro, sc, so, hc, ho;
  logic        rsw, ssw, hsw, haz;
  logic [10:0] row;
  int n_chk = 0;
  int n_fail = 0;
  int pos = 0;

  always #5 clk = ~clk;

  swtime_seq uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_cycles_i(pw),
    .term_row_i(term), .rst_close_rows_i(rc), .rst_open_rows_i(ro),
    .sel_close_rows_i(sc), .sel_open_rows_i(so),
    .hold_close_rows_i(hc), .hold_open_rows_i(ho),
    .reset_sw_o(rsw), .select_sw_o(ssw), .hold_sw_o(hsw),
    .row_o(row), .hazard_o(haz)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // row r routed = bit r-1
  function automatic logic [9:0] rm(input int r);
    return 10'(1 << (r - 1));
  endfunction

  // drive trigger at a negedge; pos 0 = just after sampling edge E0
  task automatic fire();
    @(negedge clk);
    trig = 1'b1;
    pos = -1;
    adv_to(0);
    trig = 1'b0;
  endtask

  task automatic adv_to(input int t);
    repeat (t - pos) @(negedge clk);
    pos = t;
  endtask

  task automatic t_reset();
    chk("R1 reset_sw", int'(rsw), 1);
    chk("R1 select_sw", int'(ssw), 1);
    chk("R1 hold_sw", int'(hsw), 1);
    chk("R1 row", int'(row), 1);
  endtask

  task automatic t_default();
    pw = 16'd4; term = 4'd0;
    ho = rm(3); hc = rm(6); sc = rm(4); so = rm(4); rc = rm(5); ro = rm(5);
    @(negedge clk);
    chk("R10 default no hazard", int'(haz), 0);
    fire();
    adv_to(3);  chk("R2 delay row", int'(row), 1);
    adv_to(4);  chk("R2 row1", int'(row), 2);
    adv_to(8);  chk("R2 row2", int'(row), 4);
    adv_to(16); chk("R5 select before", int'(ssw), 1);
    adv_to(17); chk("R7 select closed", int'(ssw), 0);
    adv_to(20); chk("R9 select still closed", int'(ssw), 0);
    adv_to(21); chk("R9 select reopened", int'(ssw), 1);
                chk("R6 reset closed", int'(rsw), 0);
    adv_to(24); chk("R9 reset still closed", int'(rsw), 0);
                chk("R8 hold before close", int'(hsw), 1);
    adv_to(25); chk("R9 reset reopened", int'(rsw), 1);
                chk("R8 hold closed", int'(hsw), 0);
    adv_to(43); chk("R2 row10", int'(row), 1 << 10);
    adv_to(44); chk("R2 back to idle", int'(row), 1);
    adv_to(48);
  endtask

  task automatic t_ignore();
    fire();
    adv_to(10); trig = 1'b1;
    adv_to(12); trig = 1'b0;
                chk("R4 row3 unchanged", int'(row), 1 << 3);
    adv_to(13); chk("R8 hold opened", int'(hsw), 1);
    adv_to(43); chk("R4 row10 on time", int'(row), 1 << 10);
    adv_to(44); chk("R4 idle on time", int'(row), 1);
    adv_to(50); chk("R4 no restart", int'(row), 1);
  endtask

  task automatic t_term();
    term = 4'd4; pw = 16'd4;
    fire();
    adv_to(12); chk("R8 hold closed before row3", int'(hsw), 0);
    adv_to(13); chk("R8 hold open at row3", int'(hsw), 1);
    adv_to(15); chk("R3 last row3", int'(row), 1 << 3);
    adv_to(16); chk("R3 ends after row3", int'(row), 1);
    adv_to(24); chk("R3 select untouched", int'(ssw), 1);
                chk("R3 reset untouched", int'(rsw), 1);
                chk("R3 stays idle", int'(row), 1);
    term = 4'd12; pw = 16'd2;
    fire();
    adv_to(20); chk("R3 code12 row10", int'(row), 1 << 10);
    adv_to(22); chk("R3 code12 ends", int'(row), 1);
    adv_to(24);
  endtask

  task automatic t_split();
    term = 4'd0; pw = 16'd3;
    rc = rm(2); ro = rm(7);
    fire();
    adv_to(6);  chk("R6 reset before close", int'(rsw), 1);
    adv_to(7);  chk("R6 reset closed row2", int'(rsw), 0);
    adv_to(21); chk("R6 reset held closed", int'(rsw), 0);
    adv_to(22); chk("R6 reset opened row7", int'(rsw), 1);
    adv_to(36); chk("R2 split ends", int'(row), 1);
  endtask

  task automatic t_hazard();
    term = 4'd0; ro = rm(7); hc = rm(7);
    @(negedge clk); chk("R10 coincident", int'(haz), 1);
    hc = rm(6) | rm(7);
    @(negedge clk); chk("R10 hold column starts earlier", int'(haz), 0);
    hc = rm(7); term = 4'd7;
    @(negedge clk); chk("R10 row cut by terminal", int'(haz), 0);
    term = 4'd8;
    @(negedge clk); chk("R10 row kept by terminal", int'(haz), 1);
  endtask

  initial begin
    rc = '0; ro = '0; sc = '0; so = '0; hc = '0; ho = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_default();
    t_ignore();
    t_term();
    t_split();
    t_hazard();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule